// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a serial management master for an Ethernet PHY. It runs one clause-22 style register access per request. The request carries a read/write flag, a 5-bit PHY address, a 5-bit register number and 16 bits of write data, and a one-cycle start pulse launches it. The engine produces the management clock, drives or releases the data line, and assembles read data from the PHY. It reports completion with a one-cycle done pulse, and shows a busy flag while a frame is in flight.

The frame has 65 bit slots, numbered 0 to 64:

| Slots | Content |
|---|---|
| 0 to 31 | Preamble |
| 32 to 33 | Start code |
| 34 to 35 | Opcode |
| 36 to 40 | PHY address |
| 41 to 45 | Register number |
| 46 to 47 | Turnaround |
| 48 to 63 | Data |
| 64 | Trailing released slot |

Each slot is one low phase of the management clock followed by one high phase. Each phase lasts `MDC_HALF` system clocks. The new output value is applied at the start of the low phase. The input is sampled at the last system clock of the high phase.

The data pin is split into three signals: an output value, an output enable and an input. A pad cell outside the block merges them. The asynchronous active-low reset is released through a two-stage synchroniser inside the block.

Top module: `mdio_master`

## Requirements
- R1: Slots 0 to 31 of every frame drive the line high (`mdo_en`=1, `mdo`=1).
- R2: Slots 32 and 33 drive 0 and then 1. Slots 34 and 35 drive 1,0 for a read (`req_read`=1) and 0,1 for a write.
- R3: Slots 36 to 40 drive the PHY address and slots 41 to 45 drive the register number. Each field is sent most significant bit first.
- R4: In a write, slots 46 and 47 release the line (`mdo_en`=0). Slots 48 to 63 then drive `req_wdata` most significant bit first.
- R5: In a read, slots 46 to 63 release the line. The value of `mdi` at the end of the high phase of slots 48 to 63 is assembled most significant bit first (slot 48 gives bit 15). The result appears on `rsp_rdata` in the same cycle as `rsp_done`.
- R6: Slot 64 is clocked with the line released. After the frame, `mdc`, `mdo` and `mdo_en` are all 0.
- R7: Every low phase and every high phase of `mdc` lasts exactly `MDC_HALF` system clocks. `mdo` and `mdo_en` change only while `mdc` is low.
- R8: A `req_start` while `busy` is high is ignored. The frame in flight continues unchanged and no extra frame follows.
- R9: `busy` goes high the cycle after an accepted start and stays high for 130×`MDC_HALF` cycles. `rsp_done` pulses for one cycle as `busy` falls. `rsp_rdata` changes only when a read completes.
- R10: While reset is asserted, `mdc`, `mdo`, `mdo_en`, `busy`, `rsp_done` and `rsp_rdata` are 0. Reset in mid-frame abandons the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Data from the last completed read |
| rsp_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output value |
| mdo_en | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input |

## Verification
Take the edge that accepts a start as edge 0. The outputs then change at these edges:

- `busy` and the first slot's pin values appear after edge 0.
- The rising edge of slot k appears after edge (2k+1)×`MDC_HALF`.
- `busy` falls and `rsp_done` and `rsp_rdata` update together after edge 130×`MDC_HALF`.

The bench samples every pin at the falling system-clock edge, so each registered change is seen exactly one sample after the edge that caused it. Its PHY model detects each rising edge of `mdc`. At that sample it records the pin values and presents the read bit for that slot, so the bit is stable before the sampling edge at the end of the high phase. At each done pulse, the monitor pops the expected frame and checks the following:

- the recorded slots, against the expected frame;
- the phase lengths it counted;
- the number of busy cycles;
- the read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int SLOTS   = 65;
  localparam int SW      = 7;
  localparam int S_START = 32;
  localparam int S_OP    = 34;
  localparam int S_REG   = 41;
  localparam int S_TA    = 46;
  localparam int S_DATA  = 48;
  localparam int S_IDLE  = SLOTS - 1;

  typedef logic [SW-1:0] slot_t;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
  } mdio_req_t;

  // Returns {output enable, output value} for one bit slot.
  function automatic logic [1:0] slot_drive(slot_t s, mdio_req_t r);
    int i;
    i = int'(s);
    if (i < S_START)           return 2'b11;
    else if (i == S_START)     return 2'b10;
    else if (i == S_START + 1) return 2'b11;
    else if (i == S_OP)        return {1'b1, r.rd};
    else if (i == S_OP + 1)    return {1'b1, ~r.rd};
    else if (i < S_REG)        return {1'b1, r.phy[3'(S_REG - 1 - i)]};
    else if (i < S_TA)         return {1'b1, r.rg[3'(S_TA - 1 - i)]};
    else if (i < S_DATA)       return 2'b00;
    else if (i < S_IDLE)       return r.rd ? 2'b00 : {1'b1, r.wd[4'(S_IDLE - 1 - i)]};
    else                       return 2'b00;
  endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign phase_end = run && (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_n = cnt_q;
    if (!run)           cnt_n = '0;
    else if (phase_end) cnt_n = '0;
    else                cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R7: the phase counter never passes the half-period limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HALF - 1));

endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          mdi,
  input  logic          load,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] shift_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      rdata_q <= '0;
    end else begin
      if (sample) shift_q <= {shift_q[DW-2:0], mdi};
      if (load)   rdata_q <= shift_q;
    end
  end

  assign rdata = rdata_q;

  // R9: read data holds unless a completed read loads it
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rdata_q));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_start,
  input  mdio_req_t req_in,
  input  logic      phase_end,
  output logic      busy,
  output logic      mdc,
  output logic      mdo,
  output logic      mdo_en,
  output logic      done,
  output logic      sample,
  output logic      load_rdata
);
  logic      busy_q, busy_n, hi_q, hi_n, done_q, done_n;
  logic      mdc_q, mdo_q, oe_q;
  slot_t     slot_q, slot_n;
  mdio_req_t cur_q, cur_n;
  logic [1:0] drv_n;
  logic      at_last, frame_end;

  assign at_last   = (slot_q == slot_t'(S_IDLE));
  assign frame_end = busy_q && hi_q && phase_end && at_last;

  always_comb begin
    busy_n = busy_q;
    hi_n   = hi_q;
    slot_n = slot_q;
    cur_n  = cur_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (req_start) begin
        busy_n = 1'b1;
        hi_n   = 1'b0;
        slot_n = '0;
        cur_n  = req_in;
      end
    end else if (phase_end) begin
      if (!hi_q) begin
        hi_n = 1'b1;
      end else if (at_last) begin
        busy_n = 1'b0;
        hi_n   = 1'b0;
        done_n = 1'b1;
      end else begin
        slot_n = slot_q + 1'b1;
        hi_n   = 1'b0;
      end
    end
    drv_n = busy_n ? slot_drive(slot_n, cur_n) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      slot_q <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      hi_q   <= hi_n;
      slot_q <= slot_n;
      cur_q  <= cur_n;
      done_q <= done_n;
      mdc_q  <= busy_n && hi_n;
      oe_q   <= drv_n[1];
      mdo_q  <= drv_n[0];
    end
  end

  assign sample     = busy_q && hi_q && phase_end && cur_q.rd &&
                      (slot_q >= slot_t'(S_DATA)) && (slot_q < slot_t'(S_IDLE));
  assign load_rdata = frame_end && cur_q.rd;
  assign busy       = busy_q;
  assign mdc        = mdc_q;
  assign mdo        = mdo_q;
  assign mdo_en     = oe_q;
  assign done       = done_q;

  // R6: pins rest when no frame runs
  p_idle_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !oe_q && !mdo_q));

  // R7: data pins stay put across a rising clock edge
  p_hold_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> ($stable(mdo_q) && $stable(oe_q)));

  // R9: done lasts one cycle and comes as busy falls
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)) ##1 !done_q);

  // R8: a start during a frame does not restart the slot count
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req_start && !frame_end) |=>
      (busy_q && (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic [15:0] rsp_rdata,
  output logic        rsp_done,
  output logic        busy,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_en,
  input  logic        mdi
);
  logic      rst_meta, rst_s;
  logic      phase_end, sample, load_rdata;
  mdio_req_t req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign req = '{rd: req_read, phy: req_phy, rg: req_reg, wd: req_wdata};

  mdio_phase_timer #(.HALF(MDC_HALF)) u_timer (
    .clk       (clk),
    .rst_n     (rst_s),
    .run       (busy),
    .phase_end (phase_end)
  );

  mdio_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_s),
    .req_start  (req_start),
    .req_in     (req),
    .phase_end  (phase_end),
    .busy       (busy),
    .mdc        (mdc),
    .mdo        (mdo),
    .mdo_en     (mdo_en),
    .done       (rsp_done),
    .sample     (sample),
    .load_rdata (load_rdata)
  );

  mdio_capture #(.DW(16)) u_cap (
    .clk    (clk),
    .rst_n  (rst_s),
    .sample (sample),
    .mdi    (mdi),
    .load   (load_rdata),
    .rdata  (rsp_rdata)
  );

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NSL        = 65;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] rv;
  } item_t;

  logic clk, rst_n, req_start, req_read, mdi;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata, rsp_rdata;
  logic rsp_done, busy, mdc, mdo, mdo_en;

  int checks, fails, issued, dones;
  bit finished;
  item_t exp_q[$];
  bit got_oe[NSL];
  bit got_v[NSL];
  int nslots, hi_cnt, lo_cnt, busy_cyc;
  bit timing_bad, hold_bad, mdc_prev;

  mdio_master #(.MDC_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .busy(busy),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Expected {oe,value} of a slot, written from the requirements
  function automatic logic [1:0] exp_slot(int k, item_t it);
    if (k <= 31) return 2'b11;                                   // R1
    if (k == 32) return 2'b10;                                   // R2
    if (k == 33) return 2'b11;
    if (k == 34) return it.rd ? 2'b11 : 2'b10;
    if (k == 35) return it.rd ? 2'b10 : 2'b11;
    if (k <= 40) return {1'b1, it.phy[40-k]};                    // R3
    if (k <= 45) return {1'b1, it.rg[45-k]};
    if (k <= 47) return 2'b00;                                   // R4/R5
    if (k <= 63) return it.rd ? 2'b00 : {1'b1, it.wd[63-k]};
    return 2'b00;                                                // R6
  endfunction

  task automatic cmp_range(item_t it, int lo, int hi, string tag);
    logic [63:0] a, e;
    a = '0; e = '0;
    for (int k = lo; k <= hi; k++) begin
      logic [1:0] x;
      x = exp_slot(k, it);
      if (k - lo < 32) begin
        a = {a[61:0], got_oe[k], got_v[k]};
        e = {e[61:0], x};
      end
    end
    chk(a == e, tag, a, e);
  endtask

  // PHY model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      nslots = 0; hi_cnt = 0; lo_cnt = 0; busy_cyc = 0;
      timing_bad = 0; hold_bad = 0; mdc_prev = 0; mdi = 1'b1;
    end else begin
      if (busy) busy_cyc++;
      if (mdc && !mdc_prev) begin
        if (lo_cnt != HALF) timing_bad = 1;
        lo_cnt = 0;
        if (nslots < NSL) begin
          got_oe[nslots] = mdo_en;
          got_v[nslots]  = mdo;
        end
        if (exp_q.size() > 0 && exp_q[0].rd && nslots >= 48 && nslots <= 63)
          mdi = exp_q[0].rv[63-nslots];
        else
          mdi = 1'b1;
        nslots++;
        hi_cnt = 1;
      end else if (mdc) begin
        hi_cnt++;
        if (nslots >= 1 && nslots <= NSL &&
            (mdo != got_v[nslots-1] || mdo_en != got_oe[nslots-1])) hold_bad = 1;
      end else if (busy) begin
        lo_cnt++;
      end
      if (!mdc && mdc_prev && hi_cnt != HALF) timing_bad = 1;
      if (rsp_done) begin
        item_t it;
        dones++;
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected done", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(nslots == NSL, "R6 slot count", 64'(nslots), 64'(NSL));
          if (nslots == NSL) begin
            cmp_range(it, 0, 31, "R1 preamble");
            cmp_range(it, 32, 35, "R2 start/opcode");
            cmp_range(it, 36, 45, "R3 address fields");
            cmp_range(it, 46, 63, it.rd ? "R5 turnaround/data released" : "R4 turnaround/data");
            cmp_range(it, 64, 64, "R6 trailing slot");
          end
          chk(!timing_bad, "R7 phase lengths", 64'(timing_bad), 0);
          chk(!hold_bad, "R7 pins stable while mdc high", 64'(hold_bad), 0);
          chk(busy_cyc == 130*HALF, "R9 busy length", 64'(busy_cyc), 64'(130*HALF));
          chk({mdc, mdo, mdo_en, busy} == 4'b0, "R6 idle pins after frame",
              64'({mdc, mdo, mdo_en, busy}), 0);
          if (it.rd) chk(rsp_rdata == it.rv, "R5 read data", 64'(rsp_rdata), 64'(it.rv));
        end
        nslots = 0; hi_cnt = 0; lo_cnt = 0; busy_cyc = 0;
        timing_bad = 0; hold_bad = 0;
      end
      mdc_prev = mdc;
    end
  end

  task automatic issue(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it = '{rd: rd, phy: phy, rg: rg, wd: rd ? 16'h0 : d, rv: rd ? d : 16'h0};
    exp_q.push_back(it);
    issued++;
    req_read = rd; req_phy = phy; req_reg = rg; req_wdata = rd ? 16'hDEAD : d;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; issued = 0; dones = 0; finished = 0;
    rst_n = 1'b0; req_start = 0; req_read = 0; req_phy = 0; req_reg = 0; req_wdata = 0;
    mdi = 1'b1;
    repeat (4) @(negedge clk);
    chk({mdc, mdo, mdo_en, busy, rsp_done} == 5'b0 && rsp_rdata == 0,
        "R10 reset state", 64'({mdc, mdo, mdo_en, busy, rsp_done, rsp_rdata}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(0, 5'h01, 5'h00, 16'hA5C3); wait_idle();
    issue(1, 5'h1F, 5'h02, 16'h1234); wait_idle();
    issue(1, 5'h00, 5'h1F, 16'h8001); wait_idle();

    // R8: start while busy
    issue(1, 5'h03, 5'h05, 16'hC0DE);
    repeat (60) @(negedge clk);
    req_read = 0; req_phy = 5'h1A; req_reg = 5'h0A; req_wdata = 16'h5555; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(!busy && dones == issued, "R8 no extra frame", 64'(dones), 64'(issued));

    // R9: a write leaves read data untouched
    issue(0, 5'h15, 5'h0A, 16'h0000); wait_idle();
    chk(rsp_rdata == 16'hC0DE, "R9 rdata held over write", 64'(rsp_rdata), 64'h0C0DE);
    issue(0, 5'h0A, 5'h15, 16'hFFFF); wait_idle();
    issue(1, 5'h11, 5'h11, 16'h0000); wait_idle();

    // R10: reset in mid-frame
    issue(0, 5'h02, 5'h04, 16'h3C3C);
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({mdc, mdo, mdo_en, busy, rsp_done} == 5'b0 && rsp_rdata == 0,
        "R10 mid-frame reset", 64'({mdc, mdo, mdo_en, busy, rsp_done, rsp_rdata}), 0);
    issued--;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue(1, 5'h07, 5'h1E, 16'h6A95); wait_idle();

    chk(dones == issued, "R9 done count", 64'(dones), 64'(issued));
    finish_run();
  end

endmodule